// File: doc/BRIEF.md
# External Interrupt Sense and Status Unit

This block sits between the external interrupt pins of a processor subsystem and the CPU. It takes one non-maskable interrupt pin and eight maskable request pins, synchronises each to the core clock, and detects requests according to a per-pin mode held in a control register. The NMI pin can be watched for a falling or a rising edge. Each maskable pin can be treated as active while low, or as a latched request on a falling edge.

Each maskable request is held in a status flag, and software reads and clears these flags over a small register port. A latched edge request can be withdrawn only by a handshake: software must read the flag as 1 and then write 0 to it. Writing 1 does nothing. The flags sit in reverse order within the low byte of the status word. The unit drives a one-cycle NMI request pulse and eight request lines that mirror the flags.

Top module: `xint_sense_unit`

## Requirements
- R1: After reset, the control word and the status word both read 0, and nmi_req and every irq_req bit are low.
- R2: The register port decodes reg_addr 0 as control and 1 as status; rdata is combinational and valid while reg_rd is high, and reads 0 at any other address or with reg_rd low. In control, bit 8 selects the NMI edge (0 falling, 1 rising) and bit n for n in 0..7 selects the mode of IRQn (0 low level, 1 falling edge); bits 15:9 read 0.
- R3: In the status word the flag of IRQn is at bit 7-n, so IRQ0 is at bit 7 and IRQ7 at bit 0; bits 15:8 always read 0, and writing them changes nothing.
- R4: Every pin passes through two synchroniser flops, so a pin change made between clock edges shows on irq_req on the third rising edge and not before.
- R5: In level mode a flag is 1 exactly while its synchronised pin is low, and status writes have no effect on it.
- R6: In edge mode a falling edge on the pin sets the flag, and the flag stays 1 after the pin goes high again.
- R7: In edge mode a status write of 0 to a flag clears it only if a status read returned that flag as 1 since the last status write; every status write cancels all such reads, and writing 1 never sets a flag.
- R8: If a falling edge sets a flag in the same cycle as a qualified clear of that flag, the flag stays 1.
- R9: Writing a new value to an IRQ mode bit clears that input's flag, its read marker and its edge history, so a pin held low across a switch to edge mode raises no request.
- R10: nmi_req is a pulse one cycle wide for each edge of the selected polarity on the synchronised NMI pin; in the cycle after the polarity changes no edge is detected.
- R11: Each irq_req bit equals its status flag at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| nmi_pin | input | 1 | Asynchronous non-maskable interrupt pin |
| irq_pin | input | 8 | Asynchronous maskable request pins, bit n is IRQn |
| reg_addr | input | 2 | Register select: 0 control, 1 status |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid while reg_rd is high |
| nmi_req | output | 1 | One-cycle NMI request pulse |
| irq_req | output | 8 | Maskable request lines, bit n follows the IRQn flag |

## Verification
The bench goes after the read-then-write-0 handshake: a clear with no prior read, a status write that falls between the read and the clear, and a write of all ones. A design that skips the read marker would drop requests that software never saw, and one that lets a write set a bit would create requests out of nothing. It lines up a fresh falling edge with a qualified clear in the same cycle, where a design with the wrong priority loses that edge. It also switches a pin that is held low from level mode to edge mode, where stale history would raise a false request. Random pin patterns, mode words and register traffic check the reversed bit order, level tracking and NMI pulse counts against a bench model.

// File: rtl/xint_pkg.sv
package xint_pkg;
  parameter int ADDR_W = 2;
  parameter int DATA_W = 16;
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 2'd0;
  parameter logic [ADDR_W-1:0] STAT_ADDR = 2'd1;
endpackage

// File: rtl/xint_rst_sync.sv
module xint_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int   W       = 1,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q;
  logic [W-1:0] safe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {W{RST_VAL}};
      safe_q <= {W{RST_VAL}};
    end else begin
      meta_q <= din;
      safe_q <= meta_q;
    end
  end

  assign dout = safe_q;
endmodule

// File: rtl/xint_nmi_det.sv
module xint_nmi_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic pol,
  output logic req
);
  logic hist_q, pol_q, req_q;
  logic hit;

  always_comb begin
    hit = 1'b0;
    if (pol == pol_q) begin
      if (pol) hit = !hist_q && pin_s;
      else     hit = hist_q && !pin_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 1'b1;
      pol_q  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      hist_q <= pin_s;
      pol_q  <= pol;
      req_q  <= hit;
    end
  end

  assign req = req_q;
endmodule

// File: rtl/xint_irq_chan.sv
module xint_irq_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic sense,
  input  logic sense_chg,
  input  logic stat_rd,
  input  logic stat_wr,
  input  logic wbit,
  output logic flag
);
  logic hist_q, hist_d;
  logic mark_q, mark_d;
  logic flag_q, flag_d;
  logic edge_hit, clr_ok;

  always_comb begin
    edge_hit = sense && hist_q && !pin_s;
    clr_ok   = sense && stat_wr && !wbit && mark_q;
  end

  always_comb begin
    if (sense_chg)      flag_d = 1'b0;
    else if (!sense)    flag_d = !pin_s;
    else if (edge_hit)  flag_d = 1'b1;
    else if (clr_ok)    flag_d = 1'b0;
    else                flag_d = flag_q;
  end

  always_comb begin
    if (sense_chg || stat_wr)      mark_d = 1'b0;
    else if (stat_rd && flag_q)    mark_d = 1'b1;
    else                           mark_d = mark_q;
  end

  always_comb begin
    if (sense_chg)  hist_d = 1'b0;
    else if (sense) hist_d = pin_s;
    else            hist_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 1'b0;
      mark_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      hist_q <= hist_d;
      mark_q <= mark_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/xint_sense_unit.sv
module xint_sense_unit #(
  parameter int N_IRQ = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         nmi_pin,
  input  logic [N_IRQ-1:0]             irq_pin,
  input  logic [xint_pkg::ADDR_W-1:0]  reg_addr,
  input  logic                         reg_wr,
  input  logic                         reg_rd,
  input  logic [xint_pkg::DATA_W-1:0]  reg_wdata,
  output logic [xint_pkg::DATA_W-1:0]  reg_rdata,
  output logic                         nmi_req,
  output logic [N_IRQ-1:0]             irq_req
);
  import xint_pkg::*;

  localparam int CTRL_W = N_IRQ + 1;

  logic              rst_sync_n;
  logic              nmi_s;
  logic [N_IRQ-1:0]  irq_s;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_en;
  logic [N_IRQ-1:0]  sense;
  logic              nmi_pol;
  logic [N_IRQ-1:0]  sense_chg;
  logic              stat_wr, stat_rd;
  logic [N_IRQ-1:0]  flag;
  logic [N_IRQ-1:0]  stat_vec;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-CTRL_W-1:0] wdata_unused;

  assign wdata_unused = reg_wdata[DATA_W-1:CTRL_W];

  xint_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  xint_sync #(.W(1), .RST_VAL(1'b1)) u_nmi_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .din  (nmi_pin),
    .dout (nmi_s)
  );

  xint_sync #(.W(N_IRQ), .RST_VAL(1'b1)) u_irq_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .din  (irq_pin),
    .dout (irq_s)
  );

  always_comb begin
    ctrl_en = reg_wr && (reg_addr == CTRL_ADDR);
    ctrl_d  = reg_wdata[CTRL_W-1:0];
    stat_wr = reg_wr && (reg_addr == STAT_ADDR);
    stat_rd = reg_rd && (reg_addr == STAT_ADDR);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  assign sense   = ctrl_q[N_IRQ-1:0];
  assign nmi_pol = ctrl_q[N_IRQ];

  always_comb begin
    sense_chg = '0;
    if (ctrl_en) sense_chg = ctrl_d[N_IRQ-1:0] ^ sense;
  end

  xint_nmi_det u_nmi (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .pin_s(irq_dummy_guard(nmi_s)),
    .pol  (nmi_pol),
    .req  (nmi_req)
  );

  function automatic logic irq_dummy_guard(input logic v);
    return v;
  endfunction

  genvar gi;
  generate
    for (gi = 0; gi < N_IRQ; gi++) begin : g_chan
      xint_irq_chan u_chan (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .pin_s    (irq_s[gi]),
        .sense    (sense[gi]),
        .sense_chg(sense_chg[gi]),
        .stat_rd  (stat_rd),
        .stat_wr  (stat_wr),
        .wbit     (reg_wdata[N_IRQ-1-gi]),
        .flag     (flag[gi])
      );
      assign stat_vec[N_IRQ-1-gi] = flag[gi];
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    if (reg_rd) begin
      if (reg_addr == CTRL_ADDR)      rd_word[CTRL_W-1:0] = ctrl_q;
      else if (reg_addr == STAT_ADDR) rd_word[N_IRQ-1:0]  = stat_vec;
    end
  end

  assign reg_rdata = rd_word;
  assign irq_req   = flag;
endmodule

// File: rtl/xint_sense_chk.sv
module xint_sense_chk #(
  parameter int N_IRQ = 8
) (
  input logic                        clk,
  input logic                        rst_sync_n,
  input logic [xint_pkg::ADDR_W-1:0] reg_addr,
  input logic                        reg_wr,
  input logic                        reg_rd,
  input logic [xint_pkg::DATA_W-1:0] reg_wdata,
  input logic [xint_pkg::DATA_W-1:0] reg_rdata,
  input logic                        nmi_req,
  input logic [N_IRQ-1:0]            irq_req,
  input logic [N_IRQ-1:0]            irq_s,
  input logic [N_IRQ-1:0]            sense,
  input logic [N_IRQ-1:0]            sense_chg
);
  import xint_pkg::*;

  AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    nmi_req |=> !nmi_req); // R10

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_rd && reg_addr == STAT_ADDR) |-> (reg_rdata[DATA_W-1:N_IRQ] == '0)); // R3

  genvar gi;
  generate
    for (gi = 0; gi < N_IRQ; gi++) begin : g_ast
      AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (!sense[gi] && !$past(sense[gi])) |-> (irq_req[gi] == !$past(irq_s[gi]))); // R5

      AST_EDGE_SOURCE: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (sense[gi] && $rose(irq_req[gi])) |-> $past(!irq_s[gi])); // R6

      AST_CLEAR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (sense[gi] && $past(sense[gi]) && $fell(irq_req[gi])) |->
        $past(reg_wr && reg_addr == STAT_ADDR && !reg_wdata[N_IRQ-1-gi])); // R7

      AST_MODE_SWITCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
        sense_chg[gi] |=> !irq_req[gi]); // R9
    end
  endgenerate
endmodule

bind xint_sense_unit xint_sense_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .nmi_req   (nmi_req),
  .irq_req   (irq_req),
  .irq_s     (irq_s),
  .sense     (sense),
  .sense_chg (sense_chg)
);

// File: tb/xint_sense_unit_test.sv
`timescale 1ns/1ps
module xint_sense_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        nmi_pin;
  logic [7:0]  irq_pin;
  logic [1:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        nmi_req;
  logic [7:0]  irq_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [7:0] flag_m, mark_m, hist_m, sense_m, pin_m;
  logic       pol_m, nmi_m;

  always #2.5 clk = ~clk;

  xint_sense_unit uut (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .irq_pin(irq_pin),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .nmi_req(nmi_req), .irq_req(irq_req)
  );

  function automatic logic [15:0] stat_word(input logic [7:0] f);
    logic [15:0] w = '0;
    for (int i = 0; i < 8; i++) w[7-i] = f[i];
    return w;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input string tag);
    chk(tag, {8'h00, irq_req}, {8'h00, flag_m});
  endtask

  task automatic do_ctrl(input logic [15:0] d, input string tag);
    logic [7:0] chg;
    reg_addr = 2'd0; reg_wdata = d; reg_wr = 1'b1;
    tick(1);
    reg_wr = 1'b0;
    chg = d[7:0] ^ sense_m;
    flag_m &= ~chg; mark_m &= ~chg; hist_m &= ~chg;
    sense_m = d[7:0]; pol_m = d[8];
    tick(3);
    for (int i = 0; i < 8; i++) begin
      if (sense_m[i]) hist_m[i] = pin_m[i];
      else            flag_m[i] = !pin_m[i];
    end
    chk_irq(tag);
  endtask

  task automatic do_stat_wr(input logic [15:0] d, input string tag);
    reg_addr = 2'd1; reg_wdata = d; reg_wr = 1'b1;
    tick(1);
    reg_wr = 1'b0;
    for (int i = 0; i < 8; i++)
      if (sense_m[i] && !d[7-i] && mark_m[i]) flag_m[i] = 1'b0;
    mark_m = '0;
    chk_irq(tag);
  endtask

  task automatic do_read(input logic [1:0] a, input string tag);
    logic [15:0] exp;
    case (a)
      2'd0:    exp = {7'd0, pol_m, sense_m};
      2'd1:    exp = stat_word(flag_m);
      default: exp = '0;
    endcase
    reg_addr = a; reg_rd = 1'b1;
    #1;
    chk(tag, reg_rdata, exp);
    tick(1);
    reg_rd = 1'b0;
    if (a == 2'd1) mark_m |= flag_m;
  endtask

  task automatic do_pins(input logic n, input logic [7:0] p, input string tag);
    int pulses = 0;
    int exp_p;
    nmi_pin = n; irq_pin = p;
    for (int k = 0; k < 5; k++) begin
      tick(1);
      if (nmi_req) pulses++;
    end
    exp_p = pol_m ? int'(!nmi_m && n) : int'(nmi_m && !n);
    nmi_m = n;
    for (int i = 0; i < 8; i++) begin
      if (sense_m[i]) begin
        if (hist_m[i] && !p[i]) flag_m[i] = 1'b1;
        hist_m[i] = p[i];
      end else begin
        flag_m[i] = !p[i];
      end
    end
    pin_m = p;
    chk_irq(tag);
    chk({tag, " R10 nmi pulses"}, 16'(pulses), 16'(exp_p));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; nmi_pin = 1'b1; irq_pin = 8'hFF;
    reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    flag_m = '0; mark_m = '0; hist_m = '0; sense_m = '0; pin_m = 8'hFF;
    pol_m = 1'b0; nmi_m = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    chk("R1 irq_req", {8'h00, irq_req}, 16'h0000);
    chk("R1 nmi_req", {15'd0, nmi_req}, 16'h0000);
    do_read(2'd0, "R1 R2 ctrl reset");
    do_read(2'd1, "R1 R3 stat reset");
    do_read(2'd2, "R2 unmapped addr");

    // R4 latency in level mode: IRQ3 low shows on the third edge
    irq_pin[3] = 1'b0;
    tick(2);
    chk("R4 before third edge", {8'h00, irq_req}, 16'h0000);
    tick(1);
    chk("R4 at third edge", {8'h00, irq_req}, 16'h0008);
    tick(2);
    pin_m = irq_pin; flag_m = ~pin_m;
    do_read(2'd1, "R3 reversed position of IRQ3");
    // R5 writes ignored in level mode
    do_stat_wr(16'h0000, "R5 level write 0 ignored");
    do_stat_wr(16'hFFFF, "R3 R5 write ones ignored");
    do_pins(1'b1, 8'hFF, "R5 level release");

    // R6 R7 edge mode handshake
    do_ctrl(16'h00FF, "R2 all edge mode");
    do_pins(1'b1, 8'h7E, "R6 falling edges IRQ0 IRQ7");
    do_pins(1'b1, 8'hFF, "R6 flags held after release");
    do_stat_wr(16'h0000, "R7 clear without read ignored");
    do_read(2'd1, "R3 R6 stat with IRQ0 IRQ7");
    do_stat_wr(16'hFFFF, "R7 write ones cancels marks");
    do_stat_wr(16'h0000, "R7 clear after cancelled read ignored");
    do_read(2'd1, "R7 read again");
    do_stat_wr(16'h00FE, "R7 clear only IRQ7 at bit 0");
    do_read(2'd1, "R7 IRQ0 remains");
    do_stat_wr(16'h0000, "R7 clear IRQ0");
    do_stat_wr(16'hFFFF, "R7 write one never sets");

    // R8 set wins over a clear in the same cycle
    do_pins(1'b1, 8'hFE, "R6 IRQ0 edge");
    do_read(2'd1, "R8 mark IRQ0");
    do_pins(1'b1, 8'hFF, "R8 IRQ0 high");
    irq_pin[0] = 1'b0;
    tick(2);
    reg_addr = 2'd1; reg_wdata = 16'h0000; reg_wr = 1'b1;
    tick(1);
    reg_wr = 1'b0;
    flag_m[0] = 1'b1; mark_m = '0; hist_m[0] = 1'b0; pin_m[0] = 1'b0;
    tick(2);
    chk_irq("R8 set beats clear");
    do_read(2'd1, "R8 flag still visible");
    do_stat_wr(16'h0000, "R7 later clear works");
    do_pins(1'b1, 8'hFF, "R6 release");

    // R9 switch to edge mode with pin held low
    do_ctrl(16'h00FE, "R9 IRQ0 to level");
    do_pins(1'b1, 8'hFE, "R5 IRQ0 level low");
    do_ctrl(16'h00FF, "R9 IRQ0 to edge while low");
    do_read(2'd1, "R9 no false request");

    // R10 NMI polarity
    do_pins(1'b0, 8'hFF, "R10 falling nmi");
    do_pins(1'b1, 8'hFF, "R10 rising ignored");
    do_ctrl(16'h01FF, "R2 nmi rising");
    do_read(2'd0, "R2 ctrl readback");
    do_pins(1'b0, 8'hFF, "R10 falling ignored");
    do_pins(1'b1, 8'hFF, "R10 rising nmi");

    // random traffic
    for (int s = 0; s < 400; s++) begin
      int op = $urandom_range(0, 9);
      if (op < 4)       do_pins(1'($urandom), 8'($urandom), "R5 R6 R10 R11 random pins");
      else if (op < 6)  do_read(2'($urandom_range(0, 3)), "R2 R3 random read");
      else if (op < 8)  do_stat_wr(16'($urandom), "R7 random status write");
      else if (op == 8) do_stat_wr(16'h0000, "R7 random clear");
      else              do_ctrl(16'($urandom), "R9 random mode");
    end
    do_read(2'd0, "R2 final ctrl");
    do_read(2'd1, "R11 final stat");
    finish_run();
  end
endmodule